// File: doc/BRIEF.md
# Bitwise Programmable LUT Unit

A combinational logic unit in which every bit position of the result is produced by a small lookup table. The table is shared by all bit positions, and each position indexes it with its own bits of the operands. This lets one datapath perform any two-input or three-input bitwise boolean function, with the function chosen at run time.

There are four modes, and they differ in where the table comes from:
- **Ternary-immediate:** an 8-entry table from an immediate byte. The old destination value is the third input.
- **Binary-register:** a 4-entry table taken from one nibble of the low byte of a third operand.
- **Binary-condition:** a 4-entry table taken from a 4-bit condition field.
- **Masked ternary overwrite:** works on a 4-bit field. Only the bits selected by the mask are rewritten.

Instruction decode and register file access are outside this block. The caller supplies operands that have already been read, including the old destination value.

Top module: `bit_lut_unit`

## Requirements
- R1: With mode_i = 0 (ternary-immediate), result bit i equals imm_i[k], where k = dst_i[i]*4 + a_i[i]*2 + b_i[i]. Table entry 0 is imm_i bit 0.
- R2: With mode_i = 1 and nib_hi_i = 0, the table is c_i[3:0], and result bit i equals table[a_i[i]*2 + b_i[i]]. The bits of c_i above bit 7 have no effect.
- R3: With mode_i = 1 and nib_hi_i = 1, the table is c_i[7:4], and it is indexed as in R2.
- R4: In both binary modes (mode_i = 1 and mode_i = 2), dst_i and imm_i have no effect on the result.
- R5: With mode_i = 2, the table is cond_i[3:0], and it is indexed as in R2. c_i and nib_hi_i have no effect.
- R6: With mode_i = 3, for bits i = 0..3, result bit i is the R1 lookup where mask_i[i] = 1 and dst_i[i] where mask_i[i] = 0.
- R7: With mode_i = 3, result bits above bit 3 are zero, whatever the upper operand bits are.
- R8: In mode 0, table 0xF0 returns dst_i unchanged, 0xCC returns a_i and 0xAA returns b_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | 0 ternary-immediate, 1 binary-register, 2 binary-condition, 3 masked ternary |
| dst_i | input | XLEN | old destination value (third ternary input) |
| a_i | input | XLEN | operand A |
| b_i | input | XLEN | operand B |
| c_i | input | XLEN | table source register for mode 1 |
| imm_i | input | 8 | 3-input table for modes 0 and 3 |
| nib_hi_i | input | 1 | selects the high nibble of c_i[7:0] in mode 1 |
| cond_i | input | 4 | condition field used as the table in mode 2 |
| mask_i | input | 4 | write mask for mode 3 |
| result_o | output | XLEN | result |

## Verification
The assertions watch the following on every evaluation:
- In masked mode, the upper result bits stay zero and every unmasked bit equals the old destination bit.
- The identity table 0xF0 passes the destination through.
- A register-nibble table or a condition table gives a flat result when both operands are held constant.

Some behaviour can only be shown by the bench scenarios, which compare results against an independent model:
- the exact index order of the table;
- which nibble is picked;
- that the destination is ignored in the binary modes;
- the mixed-mask merge.

// File: rtl/bit_lut_pkg.sv
package bit_lut_pkg;
  typedef enum logic [1:0] {
    MODE_TERN_IMM  = 2'd0,
    MODE_BIN_REG   = 2'd1,
    MODE_BIN_COND  = 2'd2,
    MODE_TERN_MASK = 2'd3
  } lut_mode_e;

  localparam int TBL3_W  = 8;
  localparam int TBL2_W  = 4;
  localparam int FIELD_W = 4;
endpackage

// File: rtl/lut_table_sel.sv
module lut_table_sel
  import bit_lut_pkg::*;
(
  input  lut_mode_e             mode_i,
  input  logic [TBL3_W-1:0]     imm_i,
  input  logic [TBL3_W-1:0]     c_byte_i,
  input  logic                  nib_hi_i,
  input  logic [TBL2_W-1:0]     cond_i,
  output logic [TBL3_W-1:0]     tbl_o
);
  logic [TBL2_W-1:0] tbl2;

  always_comb begin
    tbl2 = nib_hi_i ? c_byte_i[TBL3_W-1:TBL2_W] : c_byte_i[TBL2_W-1:0];
    if (mode_i == MODE_BIN_COND) tbl2 = cond_i;
  end

  // binary tables are duplicated so the dest index bit has no effect
  always_comb begin
    unique case (mode_i)
      MODE_BIN_REG, MODE_BIN_COND: tbl_o = {tbl2, tbl2};
      default:                     tbl_o = imm_i;
    endcase
  end
endmodule

// File: rtl/lut3_array.sv
module lut3_array
  import bit_lut_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [TBL3_W-1:0] tbl_i,
  input  logic [XLEN-1:0]   d_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic [XLEN-1:0]   y_o
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    logic [2:0] idx;
    assign idx    = {d_i[i], a_i[i], b_i[i]};
    assign y_o[i] = tbl_i[idx];
  end

  always_comb begin
    if (tbl_i == 8'hF0) p_ident_dst_r8: assert (y_o == d_i)
      else $error("identity table did not pass dest");
    if (tbl_i == 8'hCC) p_ident_a_r8: assert (y_o == a_i)
      else $error("0xCC table did not pass A");
  end
endmodule

// File: rtl/lut_mask_merge.sv
module lut_mask_merge
  import bit_lut_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 en_i,
  input  logic [FIELD_W-1:0]   lut_i,
  input  logic [FIELD_W-1:0]   dst_i,
  input  logic [FIELD_W-1:0]   mask_i,
  input  logic [XLEN-1:0]      full_i,
  output logic [XLEN-1:0]      y_o
);
  localparam int UPPER_W = XLEN - FIELD_W;

  logic [FIELD_W-1:0] field;

  for (genvar i = 0; i < FIELD_W; i++) begin : g_fld
    assign field[i] = mask_i[i] ? lut_i[i] : dst_i[i];
  end

  assign y_o = en_i ? {{UPPER_W{1'b0}}, field} : full_i;
endmodule

// File: rtl/bit_lut_unit.sv
module bit_lut_unit
  import bit_lut_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]        mode_i,
  input  logic [XLEN-1:0]   dst_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [XLEN-1:0]   c_i,
  input  logic [7:0]        imm_i,
  input  logic              nib_hi_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        mask_i,
  output logic [XLEN-1:0]   result_o
);
  lut_mode_e          mode;
  logic [TBL3_W-1:0]  tbl;
  logic [XLEN-1:0]    raw;
  logic               unused_c;

  assign mode     = lut_mode_e'(mode_i);
  assign unused_c = ^c_i[XLEN-1:TBL3_W];

  lut_table_sel u_tbl (
    .mode_i   (mode),
    .imm_i    (imm_i),
    .c_byte_i (c_i[TBL3_W-1:0]),
    .nib_hi_i (nib_hi_i),
    .cond_i   (cond_i),
    .tbl_o    (tbl)
  );

  lut3_array #(.XLEN(XLEN)) u_arr (
    .tbl_i (tbl),
    .d_i   (dst_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .y_o   (raw)
  );

  lut_mask_merge #(.XLEN(XLEN)) u_merge (
    .en_i   (mode == MODE_TERN_MASK),
    .lut_i  (raw[FIELD_W-1:0]),
    .dst_i  (dst_i[FIELD_W-1:0]),
    .mask_i (mask_i),
    .full_i (raw),
    .y_o    (result_o)
  );

  always_comb begin
    if (mode == MODE_TERN_MASK) begin
      p_mask_upper_r7: assert (result_o[XLEN-1:FIELD_W] == '0)
        else $error("masked mode upper bits nonzero");
      for (int i = 0; i < FIELD_W; i++)
        if (!mask_i[i]) p_mask_keep_r6: assert (result_o[i] == dst_i[i])
          else $error("unmasked bit changed");
    end
    if (mode == MODE_BIN_REG && !nib_hi_i && a_i == '0 && b_i == '0)
      p_reg_low_r2: assert (result_o == {XLEN{c_i[0]}})
        else $error("low nibble entry 0 not applied");
    if (mode == MODE_BIN_COND && a_i == '1 && b_i == '0)
      p_cond_tbl_r5: assert (result_o == {XLEN{cond_i[2]}})
        else $error("condition entry 2 not applied");
  end
endmodule

// File: tb/bit_lut_unit_test.sv
`timescale 1ns/1ps
module bit_lut_unit_test;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]      mode;
  logic [XLEN-1:0] dst, a, b, c;
  logic [7:0]      imm;
  logic            nh;
  logic [3:0]      cond, mask;
  logic [XLEN-1:0] result;

  bit_lut_unit #(.XLEN(XLEN)) uut (
    .mode_i(mode), .dst_i(dst), .a_i(a), .b_i(b), .c_i(c), .imm_i(imm),
    .nib_hi_i(nh), .cond_i(cond), .mask_i(mask), .result_o(result)
  );

  logic [XLEN-1:0] exp_q[$];
  string           tag_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [XLEN-1:0] model(
    input logic [1:0] m, input logic [XLEN-1:0] d, input logic [XLEN-1:0] x,
    input logic [XLEN-1:0] y, input logic [XLEN-1:0] z, input logic [7:0] t8,
    input logic hi, input logic [3:0] cf, input logic [3:0] mk);
    logic [XLEN-1:0] r = '0;
    logic [3:0] t4;
    t4 = (m == 2'd2) ? cf : (hi ? z[7:4] : z[3:0]);
    for (int i = 0; i < XLEN; i++) begin
      case (m)
        2'd0: r[i] = t8[{d[i], x[i], y[i]}];
        2'd1, 2'd2: r[i] = t4[{x[i], y[i]}];
        default: r[i] = (i < 4) ? (mk[i] ? t8[{d[i], x[i], y[i]}] : d[i]) : 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic drive(input string tag, input logic [1:0] m, input logic [XLEN-1:0] d,
    input logic [XLEN-1:0] x, input logic [XLEN-1:0] y, input logic [XLEN-1:0] z,
    input logic [7:0] t8, input logic hi, input logic [3:0] cf, input logic [3:0] mk);
    @(posedge clk); #1;
    mode = m; dst = d; a = x; b = y; c = z; imm = t8; nh = hi; cond = cf; mask = mk;
    exp_q.push_back(model(m, d, x, y, z, t8, hi, cf, mk));
    tag_q.push_back(tag);
  endtask

  task automatic drive_exp(input string tag, input logic [1:0] m, input logic [XLEN-1:0] d,
    input logic [XLEN-1:0] x, input logic [XLEN-1:0] y, input logic [XLEN-1:0] z,
    input logic [7:0] t8, input logic hi, input logic [3:0] cf, input logic [3:0] mk,
    input logic [XLEN-1:0] e);
    @(posedge clk); #1;
    mode = m; dst = d; a = x; b = y; c = z; imm = t8; nh = hi; cond = cf; mask = mk;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [XLEN-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (result !== e) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", t, result, e);
        end
      end
    end
  end

  localparam logic [XLEN-1:0] P1 = 64'hF0F0_3C3C_A5A5_0FF0;
  localparam logic [XLEN-1:0] P2 = 64'hCCCC_1234_5A5A_FF00;
  localparam logic [XLEN-1:0] P3 = 64'hAAAA_DEAD_BEEF_0F0F;
  localparam logic [XLEN-1:0] JUNK = 64'h9876_5432_10FE_DC00;

  initial begin
    mode = 0; dst = 0; a = 0; b = 0; c = 0; imm = 0; nh = 0; cond = 0; mask = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle: all-zero inputs
    drive_exp("R1 idle zero", 2'd0, '0, '0, '0, '0, 8'h00, 1'b0, 4'h0, 4'h0, '0);
    drive_exp("R1 xor3", 2'd0, P1, P2, P3, '0, 8'h96, 1'b0, 4'h0, 4'h0, P1 ^ P2 ^ P3);
    drive_exp("R1 majority", 2'd0, P1, P2, P3, '0, 8'hE8, 1'b0, 4'h0, 4'h0,
              (P1 & P2) | (P1 & P3) | (P2 & P3));
    drive("R1 one-hot entry 4", 2'd0, P1, P2, P3, '0, 8'h10, 1'b0, 4'h0, 4'h0);
    drive_exp("R8 identity dst", 2'd0, P1, P2, P3, JUNK, 8'hF0, 1'b1, 4'hF, 4'hF, P1);
    drive_exp("R8 pass A", 2'd0, P1, P2, P3, '0, 8'hCC, 1'b0, 4'h0, 4'h0, P2);
    drive_exp("R8 pass B", 2'd0, P1, P2, P3, '0, 8'hAA, 1'b0, 4'h0, 4'h0, P3);
    drive_exp("R2 low nibble xor", 2'd1, P1, P2, P3, {JUNK[63:8], 8'hA6}, 8'h00, 1'b0,
              4'h0, 4'h0, P2 ^ P3);
    drive_exp("R3 high nibble and", 2'd1, P1, P2, P3, {JUNK[63:8], 8'h86}, 8'h00, 1'b1,
              4'h0, 4'h0, P2 & P3);
    drive("R2 low nibble odd table", 2'd1, P1, P2, P3, 64'h0000_0000_0000_00B2, 8'h5A,
          1'b0, 4'h0, 4'h0);
    drive_exp("R4 reg mode dst ignored", 2'd1, ~P1, P2, P3, {JUNK[63:8], 8'hA6}, 8'hFF,
              1'b0, 4'h0, 4'h0, P2 ^ P3);
    drive_exp("R5 cond and", 2'd2, P1, P2, P3, JUNK, 8'h00, 1'b1, 4'h8, 4'h0, P2 & P3);
    drive_exp("R5 cond or", 2'd2, P1, P2, P3, JUNK, 8'h33, 1'b0, 4'hE, 4'h0, P2 | P3);
    drive_exp("R4 cond dst ignored", 2'd2, ~P1, P2, P3, ~JUNK, 8'hC3, 1'b1, 4'hE, 4'h0,
              P2 | P3);
    drive_exp("R6 mask all", 2'd3, 64'h5, 64'h3, 64'h9, '0, 8'h96, 1'b0, 4'h0, 4'hF,
              64'hF);
    drive_exp("R6 mask none", 2'd3, 64'h5, 64'h3, 64'h9, '0, 8'h96, 1'b0, 4'h0, 4'h0,
              64'h5);
    drive_exp("R6 mask 0101", 2'd3, 64'h5, 64'h3, 64'h9, '0, 8'h00, 1'b0, 4'h0, 4'h5,
              64'h0);
    drive_exp("R7 upper zero", 2'd3, P1, P2, P3, JUNK, 8'hFF, 1'b1, 4'hF, 4'h6,
              64'h6 | (P1 & 64'h9));
    for (int k = 0; k < 8; k++)
      drive("R1 sweep", 2'd0, P1 << k, P2 >> k, P3 ^ (P1 << k), '0, 8'h1D + 8'(k * 37),
            1'b0, 4'h0, 4'h0);
    for (int k = 0; k < 4; k++)
      drive("R6 sweep", 2'd3, P3 >> k, P1, P2 << k, '0, 8'h6B ^ 8'(k), 1'b0, 4'h0,
            4'(k * 5 + 3));
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule